// File: doc/BRIEF.md
# One-Time-Programmable Code Store Controller

This block owns a 4K-byte one-time-programmable code store, a 32-entry key table that scrambles readout, and two lock fuses. A single request carries an operation code, a 12-bit address and a data byte. Program operations each run a fixed train of program pulses: a setup window, 25 low/high pulses and a hold window. Read operations answer in the cycle after the request.

A cell "programs" by having the request data ANDed into it, so bits can only go from 1 to 0. Erased cells and erased key entries read as 0xFF. Code readout is the bitwise XNOR of the stored byte and the key entry chosen by address bits [4:0]. Because an erased entry is all ones, an unprogrammed table passes data through unchanged. The key table has no read path. The first lock fuse blocks further writes to the code array and the key table. The second lock fuse blocks code readout. The store, the key table and the fuses keep their contents through reset.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After reset `busy`, `done` and `err` are 0 and `prog_pulse_n` is 1.
- R2: An accepted program request raises `busy` in the next cycle. `busy` stays high with `prog_pulse_n` high for exactly SETUP_CLKS cycles. Then come exactly NUM_PULSES low pulses, each LOW_CLKS cycles long and separated by HIGH_CLKS high cycles. After the last pulse `busy` stays high for at least HOLD_CLKS cycles. Finally `done` is 1 for one cycle with `busy` already 0.
- R3: Code program (op 0) leaves the addressed byte equal to its old value ANDed with `din`. An erased byte is 0xFF.
- R4: Verify (op 1) sets `done` for one cycle in the cycle after the request. `dout` is then ~(code[addr] ^ key[addr[4:0]]). An erased key entry is 0xFF, so it leaves the data unchanged.
- R5: Signature read (op 2) answers like verify. Address 0x030 gives 0x15, address 0x031 gives 0x90, and any other address gives 0xFF.
- R6: Key program (op 3) ANDs `din` into key entry addr[4:0] when addr ≤ 0x1F. A higher address is refused. The key table is never driven onto `dout`.
- R7: Once the first lock is programmed (op 4), op 0 and op 3 are refused and the store is left unchanged. The second lock (op 5) can still be programmed.
- R8: Once the second lock is programmed (op 5), verify is refused. Signature reads still answer.
- R9: Op codes 6 and 7 are refused.
- R10: A refused request sets `err` for one cycle in the cycle after the request, with no `done`, no `busy` and no pulse. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the sequencing logic |
| start | input | 1 | Request strobe, sampled when idle |
| op | input | 3 | Operation code (0 code program, 1 verify, 2 signature, 3 key program, 4 lock one, 5 lock two) |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Program data |
| busy | output | 1 | Program sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | One-cycle refusal strobe |
| prog_pulse_n | output | 1 | Program pulse, active low |
| dout | output | 8 | Read result, valid with `done` of a read |

## Verification
The hardest state to reach is the one where both fuses are blown and the key table holds data. The contents survive reset and can never be cleared, so the bench cannot reach this state with repeated resets. It has to be built up in one ordered pass through the stimulus table: program code, program a key entry, blow the first fuse, attempt refused writes, blow the second fuse. Each refusal is then made visible through the verify data read back before the second fuse blocks it. Pulse timing is measured on every accepted program request, including one where a refused-looking request is issued while busy.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef logic [2:0] op_t;

  localparam op_t OP_PROG_CODE = 3'd0;
  localparam op_t OP_VERIFY    = 3'd1;
  localparam op_t OP_SIGNATURE = 3'd2;
  localparam op_t OP_PROG_KEY  = 3'd3;
  localparam op_t OP_LOCK_A    = 3'd4;
  localparam op_t OP_LOCK_B    = 3'd5;

  // Readout scrambling: XNOR of stored byte and key byte.
  function automatic logic [7:0] otp_scramble(input logic [7:0] code, input logic [7:0] key);
    return ~(code ^ key);
  endfunction

  // Fixed identification bytes.
  function automatic logic [7:0] otp_signature(input logic [31:0] a);
    case (a)
      32'h030: return 8'h15;
      32'h031: return 8'h90;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic otp_is_read(input op_t op);
    return (op == OP_VERIFY) || (op == OP_SIGNATURE);
  endfunction

  // Refusal decision from request and fuse state.
  function automatic logic otp_refused(input op_t op, input logic key_addr_ok,
                                       input logic lock_a, input logic lock_b);
    case (op)
      OP_PROG_CODE: return lock_a;
      OP_PROG_KEY:  return lock_a || !key_addr_ok;
      OP_VERIFY:    return lock_b;
      OP_SIGNATURE, OP_LOCK_A, OP_LOCK_B: return 1'b0;
      default:      return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/otp_pulse_seq.sv
module otp_pulse_seq #(
  parameter int NUM_PULSES = 25,
  parameter int SETUP_CLKS = 48,
  parameter int LOW_CLKS   = 5000,
  parameter int HIGH_CLKS  = 750,
  parameter int HOLD_CLKS  = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic active,
  output logic pulse_n,
  output logic cell_wr,
  output logic finish
);

  localparam int M1   = (SETUP_CLKS > LOW_CLKS) ? SETUP_CLKS : LOW_CLKS;
  localparam int M2   = (HIGH_CLKS > HOLD_CLKS) ? HIGH_CLKS : HOLD_CLKS;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int PW   = $clog2(NUM_PULSES + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_HOLD} seq_t;

  seq_t          state;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pulse_idx;
  logic          cnt_zero;
  logic          last_pulse;

  assign cnt_zero   = (cnt == '0);
  assign last_pulse = (pulse_idx == PW'(NUM_PULSES - 1));
  assign active     = (state != S_IDLE);
  assign pulse_n    = (state != S_LOW);
  assign cell_wr    = (state == S_LOW) && cnt_zero;
  assign finish     = (state == S_HOLD) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      pulse_idx <= '0;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          state     <= S_SETUP;
          cnt       <= CW'(SETUP_CLKS - 1);
          pulse_idx <= '0;
        end
        S_SETUP: if (cnt_zero) begin
          state <= S_LOW;
          cnt   <= CW'(LOW_CLKS - 1);
        end else cnt <= cnt - 1'b1;
        S_LOW: if (cnt_zero) begin
          state <= S_HIGH;
          cnt   <= CW'(HIGH_CLKS - 1);
        end else cnt <= cnt - 1'b1;
        S_HIGH: if (cnt_zero) begin
          if (last_pulse) begin
            state <= S_HOLD;
            cnt   <= CW'(HOLD_CLKS - 1);
          end else begin
            state     <= S_LOW;
            cnt       <= CW'(LOW_CLKS - 1);
            pulse_idx <= pulse_idx + 1'b1;
          end
        end else cnt <= cnt - 1'b1;
        S_HOLD: if (cnt_zero) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: the pulse index never runs past the last pulse.
  p_pulse_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_idx < PW'(NUM_PULSES));

  // R2: a write strobe is always followed by the pulse going high.
  p_write_ends_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cell_wr |=> pulse_n);

  // R2: the sequence ends by returning to idle.
  p_finish_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !active);

endmodule

// File: rtl/otp_store.sv
module otp_store
  import otp_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int KEY_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  op_t               wr_op,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_code,
  output logic [7:0]        rd_key,
  output logic              lock_a,
  output logic              lock_b
);

  localparam int CODE_DEPTH = 1 << ADDR_W;
  localparam int KEY_AW     = $clog2(KEY_DEPTH);

  // Non-volatile content: erased state at power-up, unaffected by reset.
  logic [7:0] code_mem [CODE_DEPTH] = '{default: 8'hFF};
  logic [7:0] key_mem  [KEY_DEPTH]  = '{default: 8'hFF};
  logic       fuse_a = 1'b0;
  logic       fuse_b = 1'b0;

  assign rd_code = code_mem[rd_addr];
  assign rd_key  = key_mem[rd_addr[KEY_AW-1:0]];
  assign lock_a  = fuse_a;
  assign lock_b  = fuse_b;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      case (wr_op)
        OP_PROG_CODE: code_mem[wr_addr] <= code_mem[wr_addr] & wr_data;
        OP_PROG_KEY:  key_mem[wr_addr[KEY_AW-1:0]] <= key_mem[wr_addr[KEY_AW-1:0]] & wr_data;
        OP_LOCK_A:    fuse_a <= 1'b1;
        OP_LOCK_B:    fuse_b <= 1'b1;
        default: ;
      endcase
    end
  end

  // R7: no write reaches the code array or key table once fuse one is blown.
  p_no_write_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_op == OP_PROG_CODE || wr_op == OP_PROG_KEY)) |-> !fuse_a);

  // R7: fuses never clear.
  p_fuse_a_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n) !$fell(fuse_a));
  p_fuse_b_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n) !$fell(fuse_b));

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int KEY_DEPTH  = 32,
  parameter int NUM_PULSES = 25,
  parameter int SETUP_CLKS = 48,
  parameter int LOW_CLKS   = 5000,
  parameter int HIGH_CLKS  = 750,
  parameter int HOLD_CLKS  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              prog_pulse_n,
  output logic [7:0]        dout
);

  localparam int KEY_AW = $clog2(KEY_DEPTH);

  op_t               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              done_q, err_q;
  logic [7:0]        dout_q;

  logic       seq_active, seq_pulse_n, cell_wr, seq_finish;
  logic [7:0] rd_code, rd_key, rd_value;
  logic       lock_a, lock_b;
  logic       req, key_addr_ok, refuse, go_prog;

  assign key_addr_ok = (addr >> KEY_AW) == '0;
  assign req         = start && !seq_active;
  assign refuse      = otp_refused(op, key_addr_ok, lock_a, lock_b);
  assign go_prog     = req && !refuse && !otp_is_read(op);
  assign rd_value    = (op == OP_VERIFY) ? otp_scramble(rd_code, rd_key)
                                         : otp_signature(32'(addr));

  otp_pulse_seq #(
    .NUM_PULSES(NUM_PULSES), .SETUP_CLKS(SETUP_CLKS), .LOW_CLKS(LOW_CLKS),
    .HIGH_CLKS(HIGH_CLKS), .HOLD_CLKS(HOLD_CLKS)
  ) i_seq (
    .clk(clk), .rst_n(rst_n), .go(go_prog), .active(seq_active),
    .pulse_n(seq_pulse_n), .cell_wr(cell_wr), .finish(seq_finish)
  );

  otp_store #(.ADDR_W(ADDR_W), .KEY_DEPTH(KEY_DEPTH)) i_store (
    .clk(clk), .rst_n(rst_n), .wr_en(cell_wr), .wr_op(op_q), .wr_addr(addr_q),
    .wr_data(data_q), .rd_addr(addr), .rd_code(rd_code), .rd_key(rd_key),
    .lock_a(lock_a), .lock_b(lock_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_PROG_CODE;
      addr_q <= '0;
      data_q <= 8'hFF;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      dout_q <= 8'hFF;
    end else begin
      done_q <= seq_finish;
      err_q  <= 1'b0;
      if (req) begin
        if (refuse) err_q <= 1'b1;
        else if (otp_is_read(op)) begin
          done_q <= 1'b1;
          dout_q <= rd_value;
        end else begin
          op_q   <= op;
          addr_q <= addr;
          data_q <= din;
        end
      end
    end
  end

  assign busy         = seq_active;
  assign done         = done_q;
  assign err          = err_q;
  assign prog_pulse_n = seq_pulse_n;
  assign dout         = dout_q;

  // R2: pulses only occur inside a busy sequence.
  p_pulse_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_pulse_n |-> busy);

  // R2: the latched request does not move while the sequence runs.
  p_latch_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(data_q) && $stable(op_q)));

  // R10: a refusal never coincides with completion, busy or a pulse.
  p_err_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!done && !busy && prog_pulse_n));

  // R10: refusal strobe lasts a single cycle.
  p_err_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

endmodule

// File: tb/test_otp_prog_ctrl.sv
module test_otp_prog_ctrl;

  localparam int NP = 25, SU = 48, LO = 6, HI = 3, HO = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] op = 3'd0;
  logic [11:0] addr = '0;
  logic [7:0] din = '0;
  logic busy, done, err, prog_pulse_n;
  logic [7:0] dout;

  int n_tests = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  otp_prog_ctrl #(.NUM_PULSES(NP), .SETUP_CLKS(SU), .LOW_CLKS(LO),
                  .HIGH_CLKS(HI), .HOLD_CLKS(HO)) i_otp_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .din(din),
    .busy(busy), .done(done), .err(err), .prog_pulse_n(prog_pulse_n), .dout(dout)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [11:0] addr;
    logic [7:0]  din;
    logic        exp_err;
    logic        chk_data;
    logic [7:0]  exp_data;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 12'h123, 8'h00, 1'b0, 1'b1, 8'hFF}, // R4 erased code, erased key
    '{3'd2, 12'h030, 8'h00, 1'b0, 1'b1, 8'h15}, // R5
    '{3'd2, 12'h031, 8'h00, 1'b0, 1'b1, 8'h90}, // R5
    '{3'd2, 12'h032, 8'h00, 1'b0, 1'b1, 8'hFF}, // R5 other address
    '{3'd0, 12'h123, 8'hA5, 1'b0, 1'b0, 8'h00}, // R2 R3
    '{3'd0, 12'h123, 8'h3C, 1'b0, 1'b0, 8'h00}, // R3 second write ANDs
    '{3'd1, 12'h123, 8'h00, 1'b0, 1'b1, 8'h24}, // R3 A5&3C
    '{3'd3, 12'h003, 8'h0F, 1'b0, 1'b0, 8'h00}, // R6 key entry 3
    '{3'd1, 12'h123, 8'h00, 1'b0, 1'b1, 8'hD4}, // R4 ~(24^0F)
    '{3'd1, 12'h023, 8'h00, 1'b0, 1'b1, 8'h0F}, // R4 ~(FF^0F)
    '{3'd3, 12'h020, 8'h00, 1'b1, 1'b0, 8'h00}, // R6 out of key range
    '{3'd6, 12'h000, 8'h00, 1'b1, 1'b0, 8'h00}, // R9
    '{3'd7, 12'h000, 8'h00, 1'b1, 1'b0, 8'h00}, // R9
    '{3'd4, 12'h000, 8'h00, 1'b0, 1'b0, 8'h00}, // R7 blow fuse one
    '{3'd0, 12'h123, 8'h00, 1'b1, 1'b0, 8'h00}, // R7 code write refused
    '{3'd3, 12'h001, 8'h00, 1'b1, 1'b0, 8'h00}, // R7 key write refused
    '{3'd1, 12'h123, 8'h00, 1'b0, 1'b1, 8'hD4}, // R7 code unchanged
    '{3'd1, 12'h001, 8'h00, 1'b0, 1'b1, 8'hFF}, // R7 key entry 1 unchanged
    '{3'd5, 12'h000, 8'h00, 1'b0, 1'b0, 8'h00}, // R7 fuse two still accepted
    '{3'd1, 12'h123, 8'h00, 1'b1, 1'b0, 8'h00}, // R8 verify refused
    '{3'd2, 12'h031, 8'h00, 1'b0, 1'b1, 8'h90}  // R8 signature still works
  };

  // Observations of the last operation.
  logic got_err, got_done, done_busy;
  logic [7:0] got_data;
  int n_setup, n_pulses, low_min, low_max, n_tail, n_busy, n_low, n_done, n_err;

  function automatic string tag_of(input vec_t v);
    if (v.op > 3'd5) return "R9";
    if (v.exp_err) begin
      if (v.op == 3'd1) return "R8";
      if (v.op == 3'd3 && v.addr > 12'h01F) return "R6";
      return "R7";
    end
    if (v.op == 3'd2) return "R5";
    if (v.op == 3'd1) return "R3,R4";
    return "R2";
  endfunction

  task automatic check(input string tag, input string what, input logic ok,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Issue one request and observe until done or err (or a bound).
  task automatic do_op(input logic [2:0] o, input logic [11:0] a, input logic [7:0] d,
                       input logic poke_mid);
    logic prev_n;
    int run;
    @(negedge clk);
    op = o; addr = a; din = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_err = 0; got_done = 0; done_busy = 0; got_data = 8'h00;
    n_setup = 0; n_pulses = 0; low_min = 1 << 30; low_max = 0; n_tail = 0;
    n_busy = 0; n_low = 0; n_done = 0; n_err = 0;
    prev_n = 1'b1; run = 0;
    for (int c = 0; c < 5000; c++) begin
      if (busy) n_busy++;
      if (!prog_pulse_n) begin
        n_low++;
        if (prev_n) n_pulses++;
        run++;
      end else begin
        if (!prev_n) begin
          if (run < low_min) low_min = run;
          if (run > low_max) low_max = run;
          run = 0;
        end
        if (busy && n_pulses == 0) n_setup++;
        if (busy && n_pulses == NP) n_tail++;
      end
      prev_n = prog_pulse_n;
      if (err) begin got_err = 1; n_err++; end
      if (done) begin
        got_done = 1; n_done++; got_data = dout; done_busy = busy;
      end
      if (poke_mid && c == 100) begin
        op = 3'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        continue;
      end
      if ((err || done) && !busy) begin
        // look a few more cycles for stray strobes
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          if (err) n_err++;
          if (done) n_done++;
          if (busy) n_busy++;
        end
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(20ns * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "busy at reset", busy === 1'b0, busy, 0);
    check("R1", "done/err at reset", (done === 1'b0) && (err === 1'b0), {done, err}, 0);
    check("R1", "pulse at reset", prog_pulse_n === 1'b1, prog_pulse_n, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string t;
      v = VEC[i];
      t = tag_of(v);
      do_op(v.op, v.addr, v.din, 1'b0);
      check(t, "err flag", got_err == v.exp_err, got_err, v.exp_err);
      if (v.exp_err) begin
        // R10: refusal leaves no trace of a sequence
        check("R10", "refusal side effects", (n_done == 0) && (n_busy == 0) &&
              (n_low == 0) && (n_err == 1), {n_done, n_busy, n_low}, 0);
      end else begin
        check(t, "done seen once", got_done && n_done == 1, n_done, 1);
        if (v.chk_data)
          check(t, "read data", got_data == v.exp_data, got_data, v.exp_data);
        else begin
          check("R2", "setup cycles", n_setup == SU, n_setup, SU);
          check("R2", "pulse count", n_pulses == NP, n_pulses, NP);
          check("R2", "low width", low_min == LO && low_max == LO, low_max, LO);
          check("R2", "hold cycles", n_tail >= HO, n_tail, HO);
          check("R2", "busy low at done", done_busy == 1'b0, done_busy, 0);
        end
      end
    end

    // R10: start during busy is ignored (fuse two program repeats, poke op 7)
    do_op(3'd5, 12'h000, 8'h00, 1'b1);
    check("R10", "no err while busy", n_err == 0, n_err, 0);
    check("R10", "single done", n_done == 1, n_done, 1);
    check("R10", "pulse count intact", n_pulses == NP, n_pulses, NP);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule